// File: doc/BRIEF.md
# DDR2 Bank Precharge Timing Guard

This block sits in the command path of a DDR2 memory controller, next to the scheduler. It watches every command the scheduler issues to the device. For each of eight banks it keeps two countdowns:

- one gives the earliest cycle at which a precharge may reach that bank;
- the other gives the cycle at which the bank's precharge period has run out.

The scheduler reads the outputs combinationally. It uses them to decide whether a single-bank precharge or an all-bank precharge may go out in the current cycle, and whether a bank has finished precharging.

Reads and reads with auto-precharge hold off a later precharge by the additive latency, plus half the burst, plus the larger of the read-to-precharge count and two, minus two. Writes, with or without auto-precharge, hold it off by the write latency, plus half the burst, plus the write recovery count. A new constraint never shortens one that is still pending. A precharge to one bank, or to all banks, restarts the recovery countdown of every bank it covers.

Configuration is given in clock cycles and must be held steady between resets. The read-to-precharge count is the read-to-precharge time divided by the clock period, rounded up.

Top module: `ddr2_pre_guard`

## Requirements
- R1: After a synchronous reset, every bit of `preOk`, `preAllOk` and every bit of `bankReady` are 1.
- R2: A read (cmdKind 0) or a read with auto-precharge (cmdKind 2) accepted on edge E makes `preOk` of that bank low until a precharge could be accepted on edge E + AL + BL/2 + max(RTP,2) − 2. BL is 8 when `cfgBl8` is 1 and 4 when it is 0.
- R3: A write (cmdKind 1) accepted on edge E holds `preOk` of its bank low until edge E + WL + BL/2 + cfgWr.
- R4: A write with auto-precharge (cmdKind 3) uses the same spacing as R3, with cfgWr taken as WR.
- R5: A single-bank precharge (cmdKind 4) or an all-bank precharge (cmdKind 5) leaves `preOk` high, so a further precharge may follow one cycle later.
- R6: When a new command carries a shorter constraint than the one pending on its bank, the longer constraint still applies.
- R7: A command to one bank leaves the `preOk` and `bankReady` bits of every other bank unchanged, except for an all-bank precharge.
- R8: `preAllOk` is 1 exactly when all eight `preOk` bits are 1.
- R9: A precharge to a bank accepted on edge E drives its `bankReady` bit low. The bit returns high so that a command could be accepted on edge E + cfgRp (cfgRp ≥ 1).
- R10: An all-bank precharge restarts the R9 countdown on all eight banks.
- R11: A cycle with `cmdValid` low, or with cmdKind 6 or 7, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | A command is accepted this cycle |
| cmdKind | input | 3 | 0 read, 1 write, 2 read+AP, 3 write+AP, 4 precharge, 5 precharge all |
| cmdBank | input | 3 | Target bank |
| cfgAl | input | 4 | Additive latency, cycles |
| cfgWl | input | 4 | Write latency, cycles |
| cfgBl8 | input | 1 | 1 for burst of 8, 0 for burst of 4 |
| cfgRtp | input | 4 | Read-to-precharge, cycles |
| cfgWr | input | 5 | Write recovery, cycles |
| cfgRp | input | 5 | Precharge period, cycles |
| preOk | output | 8 | Per bank: precharge allowed this cycle |
| preAllOk | output | 1 | Precharge of all banks allowed this cycle |
| bankReady | output | 8 | Per bank: precharge period complete |

## Verification
The properties rely on three conditions:

- the configuration inputs do not move while any countdown is running;
- cfgRp is at least 1;
- a precharge is only presented while the guard allows it.

The stimulus meets all three. It changes the configuration only under reset, and it sends precharges only after the model's earliest cycle has passed. The sweep covers every command kind across a grid of latencies, burst lengths, read-to-precharge counts with values on both sides of two, recovery counts and precharge periods. Directed sequences then cover overlapping constraints, blocking of the all-bank precharge, and ignored commands.

// File: rtl/pg_pkg.sv
package pg_pkg;
  parameter int NUM_BANKS = 8;
  parameter int CNT_W = 6;

  typedef enum logic [2:0] {
    CMD_RD   = 3'd0,
    CMD_WR   = 3'd1,
    CMD_RDA  = 3'd2,
    CMD_WRA  = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] gapHit;
    logic [CNT_W-1:0]     gapLoad;
    logic [NUM_BANKS-1:0] rpHit;
    logic [CNT_W-1:0]     rpLoad;
  } strobes_t;
endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
#(
  parameter int AL_W  = 4,
  parameter int WL_W  = 4,
  parameter int RTP_W = 4,
  parameter int WR_W  = 5,
  parameter int RP_W  = 5,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              cmdValid,
  input  logic [2:0]        cmdKind,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [AL_W-1:0]   cfgAl,
  input  logic [WL_W-1:0]   cfgWl,
  input  logic              cfgBl8,
  input  logic [RTP_W-1:0]  cfgRtp,
  input  logic [WR_W-1:0]   cfgWr,
  input  logic [RP_W-1:0]   cfgRp,
  output strobes_t          strobes
);
  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] halfBurst;
  logic [SUM_W-1:0] rtpEff;
  logic [SUM_W-1:0] readLoad;
  logic [SUM_W-1:0] writeLoad;
  logic [NUM_BANKS-1:0] bankSel;

  always_comb begin
    halfBurst = cfgBl8 ? SUM_W'(4) : SUM_W'(2);
    rtpEff    = (cfgRtp > RTP_W'(2)) ? SUM_W'(cfgRtp) : SUM_W'(2);
    // counter holds gap-1: it reads zero in the cycle before the allowed edge
    readLoad  = SUM_W'(cfgAl) + halfBurst + rtpEff - SUM_W'(3);
    writeLoad = SUM_W'(cfgWl) + halfBurst + SUM_W'(cfgWr) - SUM_W'(1);
    bankSel   = NUM_BANKS'(1) << cmdBank;
  end

  always_comb begin
    strobes.gapHit  = '0;
    strobes.gapLoad = '0;
    strobes.rpHit   = '0;
    strobes.rpLoad  = (cfgRp == '0) ? '0 : CNT_W'(cfgRp - RP_W'(1));
    if (cmdValid) begin
      unique case (cmdKind)
        CMD_RD, CMD_RDA: begin
          strobes.gapHit  = bankSel;
          strobes.gapLoad = CNT_W'(readLoad);
        end
        CMD_WR, CMD_WRA: begin
          strobes.gapHit  = bankSel;
          strobes.gapLoad = CNT_W'(writeLoad);
        end
        CMD_PRE:  strobes.rpHit = bankSel;
        CMD_PREA: strobes.rpHit = '1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pg_timers.sv
module pg_timers
  import pg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  strobes_t             strobes,
  output logic [NUM_BANKS-1:0] preOk,
  output logic                 preAllOk,
  output logic [NUM_BANKS-1:0] bankReady
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] gapCnt, gapDec, gapNext;
    logic [CNT_W-1:0] rpCnt, rpNext;

    always_comb begin
      gapDec  = (gapCnt == '0) ? '0 : gapCnt - CNT_W'(1);
      gapNext = gapDec;
      if (strobes.gapHit[b] && strobes.gapLoad > gapDec) gapNext = strobes.gapLoad;
      rpNext = (rpCnt == '0) ? '0 : rpCnt - CNT_W'(1);
      if (strobes.rpHit[b]) rpNext = strobes.rpLoad;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        gapCnt <= '0;
        rpCnt  <= '0;
      end else begin
        gapCnt <= gapNext;
        rpCnt  <= rpNext;
      end
    end

    assign preOk[b]     = (gapCnt == '0);
    assign bankReady[b] = (rpCnt == '0);
  end

  assign preAllOk = &preOk;
endmodule

// File: rtl/ddr2_pre_guard.sv
module ddr2_pre_guard
  import pg_pkg::*;
#(
  parameter int AL_W  = 4,
  parameter int WL_W  = 4,
  parameter int RTP_W = 4,
  parameter int WR_W  = 5,
  parameter int RP_W  = 5,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdKind,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [AL_W-1:0]      cfgAl,
  input  logic [WL_W-1:0]      cfgWl,
  input  logic                 cfgBl8,
  input  logic [RTP_W-1:0]     cfgRtp,
  input  logic [WR_W-1:0]      cfgWr,
  input  logic [RP_W-1:0]      cfgRp,
  output logic [NUM_BANKS-1:0] preOk,
  output logic                 preAllOk,
  output logic [NUM_BANKS-1:0] bankReady
);
  strobes_t strobes;

  pg_ctrl #(
    .AL_W(AL_W), .WL_W(WL_W), .RTP_W(RTP_W), .WR_W(WR_W), .RP_W(RP_W)
  ) u_ctrl (
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cfgAl(cfgAl), .cfgWl(cfgWl), .cfgBl8(cfgBl8), .cfgRtp(cfgRtp),
    .cfgWr(cfgWr), .cfgRp(cfgRp), .strobes(strobes)
  );

  pg_timers u_timers (
    .clk(clk), .rst(rst), .strobes(strobes),
    .preOk(preOk), .preAllOk(preAllOk), .bankReady(bankReady)
  );
endmodule

// File: rtl/pg_guard_checker.sv
module pg_guard_checker
  import pg_pkg::*;
#(
  parameter int RP_W = 5,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmdValid,
  input logic [2:0]           cmdKind,
  input logic [BANK_W-1:0]    cmdBank,
  input logic [RP_W-1:0]      cfgRp,
  input logic [NUM_BANKS-1:0] preOk,
  input logic                 preAllOk,
  input logic [NUM_BANKS-1:0] bankReady
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (preAllOk && preOk == '1 && bankReady == '1));

  // R2
  read_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && (cmdKind == 3'd0 || cmdKind == 3'd2)) |=> !preOk[$past(cmdBank)]);

  // R3
  write_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && (cmdKind == 3'd1 || cmdKind == 3'd3)) |=> !preOk[$past(cmdBank)]);

  // R8
  all_needs_each_chk: assert property (@(posedge clk) disable iff (rst)
    preAllOk |-> $countones(preOk) == NUM_BANKS);

  // R10
  prea_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdKind == 3'd5 && cfgRp > RP_W'(1)) |=> bankReady == '0);

  // R11
  idle_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdKind > 3'd5) |=>
      ((preOk & $past(preOk)) == $past(preOk) && (bankReady & $past(bankReady)) == $past(bankReady)));
endmodule

bind ddr2_pre_guard pg_guard_checker #(.RP_W(RP_W)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
  .cfgRp(cfgRp), .preOk(preOk), .preAllOk(preAllOk), .bankReady(bankReady)
);

// File: tb/ddr2_pre_guard_bench.sv
module ddr2_pre_guard_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [2:0] cmdKind = 3'd0;
  logic [2:0] cmdBank = 3'd0;
  logic [3:0] cfgAl = 4'd0, cfgWl = 4'd1, cfgRtp = 4'd2;
  logic cfgBl8 = 1'b0;
  logic [4:0] cfgWr = 5'd2, cfgRp = 5'd2;
  logic [7:0] preOk, bankReady;
  logic preAllOk;

  int checks = 0, errors = 0, cyc = 0;
  int earliest [8];
  int readyAt [8];
  string curReq = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  ddr2_pre_guard u_ddr2_pre_guard (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cfgAl(cfgAl), .cfgWl(cfgWl), .cfgBl8(cfgBl8), .cfgRtp(cfgRtp), .cfgWr(cfgWr),
    .cfgRp(cfgRp), .preOk(preOk), .preAllOk(preAllOk), .bankReady(bankReady)
  );

  function automatic int maxi(int a, int b);
    return a > b ? a : b;
  endfunction

  function automatic int readGap();
    return cfgAl + (cfgBl8 ? 4 : 2) + maxi(cfgRtp, 2) - 2;
  endfunction

  function automatic int writeGap();
    return cfgWl + (cfgBl8 ? 4 : 2) + cfgWr;
  endfunction

  task automatic checkOutputs();
    logic [7:0] expOk, expRdy;
    for (int b = 0; b < 8; b++) begin
      expOk[b]  = (cyc + 1 >= earliest[b]);
      expRdy[b] = (cyc + 1 >= readyAt[b]);
    end
    checks += 3;
    if (preOk !== expOk) begin
      errors++;
      $display("FAIL %s preOk actual %b expected %b (cycle %0d)", curReq, preOk, expOk, cyc);
    end
    // R8: all-bank permission follows every bank
    if (preAllOk !== (&expOk)) begin
      errors++;
      $display("FAIL R8 preAllOk actual %b expected %b (cycle %0d)", preAllOk, &expOk, cyc);
    end
    if (bankReady !== expRdy) begin
      errors++;
      $display("FAIL %s bankReady actual %b expected %b (cycle %0d)", curReq, bankReady, expRdy, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] k, input logic [2:0] b);
    cmdValid = v;
    cmdKind  = k;
    cmdBank  = b;
    @(posedge clk);
    cyc++;
    if (v) begin
      case (k)
        3'd0, 3'd2: earliest[b] = maxi(earliest[b], cyc + readGap());
        3'd1, 3'd3: earliest[b] = maxi(earliest[b], cyc + writeGap());
        3'd4: begin
          earliest[b] = maxi(earliest[b], cyc + 1);
          readyAt[b]  = cyc + cfgRp;
        end
        3'd5: for (int i = 0; i < 8; i++) begin
          earliest[i] = maxi(earliest[i], cyc + 1);
          readyAt[i]  = cyc + cfgRp;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    cmdValid = 1'b0;
    checkOutputs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 3'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cmdValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < 8; b++) begin
      earliest[b] = 0;
      readyAt[b] = 0;
    end
    cyc = 0;
    curReq = "R1";
    checkOutputs();
  endtask

  initial begin
    int scen;
    scen = 0;
    for (int al = 0; al < 3; al++)
      for (int bl = 0; bl < 2; bl++)
        for (int rtp = 1; rtp < 5; rtp++)
          for (int wr = 2; wr < 4; wr++)
            for (int rp = 2; rp < 4; rp++)
              for (int k = 0; k < 4; k++) begin
                cfgAl = 4'(al); cfgWl = 4'(al + 1); cfgBl8 = bl[0];
                cfgRtp = 4'(rtp); cfgWr = 5'(wr); cfgRp = 5'(rp);
                doReset();
                // R2 reads, R3 write, R4 write with auto-precharge; R7 others stay high
                curReq = (k == 0 || k == 2) ? "R2" : (k == 1 ? "R3" : "R4");
                step(1'b1, 3'(k), 3'(scen % 8));
                idle(14);
                curReq = "R9";
                step(1'b1, 3'd4, 3'(scen % 8));
                curReq = "R5";
                step(1'b1, 3'd4, 3'(scen % 8));
                idle(4);
                curReq = "R10";
                step(1'b1, 3'd5, 3'd0);
                idle(4);
                scen++;
              end

    cfgAl = 4'd1; cfgWl = 4'd2; cfgBl8 = 1'b1; cfgRtp = 4'd3; cfgWr = 5'd3; cfgRp = 5'd4;
    doReset();
    // R6: write then shorter read on the same bank
    curReq = "R6";
    step(1'b1, 3'd1, 3'd2);
    step(1'b1, 3'd0, 3'd2);
    idle(12);
    // R7: read on bank 5 leaves others; R8 blocks precharge-all
    curReq = "R7";
    step(1'b1, 3'd0, 3'd5);
    step(1'b1, 3'd4, 3'd1);
    idle(8);
    // R11: invalid kinds and unqualified commands ignored
    curReq = "R11";
    step(1'b0, 3'd1, 3'd3);
    step(1'b1, 3'd6, 3'd3);
    step(1'b1, 3'd7, 3'd4);
    step(1'b0, 3'd5, 3'd0);
    idle(2);
    // R10: precharge-all restarts a bank already counting
    curReq = "R10";
    step(1'b1, 3'd4, 3'd6);
    step(1'b1, 3'd5, 3'd0);
    idle(6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule